// File: doc/BRIEF.md
# I2C Slave Port Expander Engine

This block is the serial-bus slave of an eight-bit open-drain I/O expander. It runs on a fast system clock that oversamples the bus clock and data lines. It recognises START and STOP conditions and receives a seven-bit device address followed by a direction bit. If the address matches, it acknowledges the address. A write transfer loads each received data byte into the port output register. A read transfer returns the live port levels and the latched transition flags, one after the other, for as long as the master keeps acknowledging.

The surrounding expander provides the low four address bits, the port input levels and the transition flags. The block returns a one-cycle snapshot strobe each time the port levels are sampled. The transition-detection logic uses this strobe to reload its reference and clear its flags. The pad drivers are outside the block. The data line is modelled as a received level plus an output enable that pulls the line low. A separate active-low abort input returns the interface to its stopped state at any time.

Top module: `pexp_i2c_engine`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next cycle shows `sda_oe` low, `snap_stb` low and `port_out` equal to the parameter `PORT_INIT` (default 8'hFF).
- R2: The first byte after START is received MSB first. Its bits [7:1] are the device address and bit 0 is the direction (1 = read, 0 = write). The block acknowledges by driving SDA low during the ninth clock only when bits [7:1] equal 3'b110 followed by `addr_low`. Any other address gets no acknowledge, and `port_out` does not change.
- R3: During a write, every data byte after the address is acknowledged and copied whole into `port_out` by the end of that byte's acknowledge clock. This repeats for every byte until STOP.
- R4: During a read, the first byte sent, MSB first, is `port_in` as sampled on the rising edge of the address acknowledge clock. The second byte is `flags_in` as captured at that same edge.
- R5: A read continues to alternate between a port byte and a flag byte while the master acknowledges. Each later port byte is resampled, together with a fresh flag capture, at the master acknowledge that comes just before it.
- R6: `snap_stb` pulses for exactly one cycle at the address acknowledge of every matched transfer, read or write, and also at each resample described in R5. It never pulses for an unmatched address.
- R7: When the master does not acknowledge a read byte (SDA high in the ninth clock), the block releases SDA. It then ignores further clocks until the next START or STOP.
- R8: While `abort_n` is low, the block enters the stopped state with SDA released. Clocked bytes sent after the abort and before a new START are not acknowledged and leave `port_out` unchanged.
- R9: A repeated START in the middle of a transfer restarts the address phase, so a write can be followed directly by a read.
- R10: After a STOP, bytes clocked without a new START are not acknowledged and do not change `port_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the bus clock rate |
| rst_n | input | 1 | Synchronous active-low reset |
| abort_n | input | 1 | Active-low transaction abort; forces the stopped state |
| scl_in | input | 1 | Bus clock level |
| sda_in | input | 1 | Bus data level as seen on the wire |
| sda_oe | output | 1 | When high, the data line is pulled low |
| addr_low | input | 4 | Low four device address bits from the address decoder |
| port_in | input | 8 | Live port input levels |
| flags_in | input | 8 | Transition flags from the detection logic |
| port_out | output | 8 | Port output register (1 = released, 0 = pulled low) |
| snap_stb | output | 1 | One-cycle pulse whenever the port levels are sampled |

## Verification
A table of single transfers covers several cases. These are reads and writes to the matching address, addresses that differ only in the low nibble, and addresses that differ in the fixed upper bits. Together they separate correct address comparison from partial comparison and show that a rejected transfer leaves the port register alone. A four-byte read changes `port_in` and `flags_in` partway through. This shows whether the third byte was really resampled and whether the flag byte follows its own capture rather than the live input. Separate sequences cover the other cases. A master NACK with all-zero port data makes any unwanted drive visible as zero bits. A mid-transfer abort, bytes sent after STOP, and a write followed by a repeated-START read each check that a return to the stopped state really ignores later clocks.

// File: rtl/pexp_pkg.sv
// Shared constants and the engine state type.
// Assumes a byte-oriented two-wire bus with 7-bit device addressing.
package pexp_pkg;
    localparam int BYTE_W = 8;
    localparam int HI_W   = 3;
    localparam int LOW_W  = 4;

    typedef enum logic [2:0] {
        ST_IDLE,   // stopped, waiting for START
        ST_ADDR,   // receiving address + direction
        ST_AACK,   // driving address acknowledge
        ST_WDATA,  // receiving a write byte
        ST_WACK,   // driving write-byte acknowledge
        ST_RDATA,  // sending a read byte
        ST_RACK,   // sampling master acknowledge
        ST_WAIT    // ignoring the bus until START or STOP
    } state_t;
endpackage

// File: rtl/pexp_line_sync.sv
// Synchronises the bus clock and data lines into the system clock and
// derives clock edges and START/STOP conditions from the synchronised
// levels. Assumes STAGES >= 2 and a system clock well above the bus rate.
module pexp_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int LINES = 2;  // index 0 = clock line, 1 = data line

    logic [LINES-1:0] raw;
    logic [LINES-1:0] lvl;
    logic [LINES-1:0] lvl_q;

    assign raw = {sda_in, scl_in};

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] chain;
        // Shift the raw level through the synchroniser chain; idle bus is high.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-2:0], raw[g]};
        end
        assign lvl[g] = chain[STAGES-1];
    end

    // Hold the previous synchronised levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= '1;
        else        lvl_q <= lvl;
    end

    assign sda_lvl   = lvl[1];
    assign scl_rise  =  lvl[0] & ~lvl_q[0];
    assign scl_fall  = ~lvl[0] &  lvl_q[0];
    assign start_det =  lvl[0] &  lvl_q[0] &  lvl_q[1] & ~lvl[1];
    assign stop_det  =  lvl[0] &  lvl_q[0] & ~lvl_q[1] &  lvl[1];
endmodule

// File: rtl/pexp_rx_shift.sv
// Receive shift register with a saturating bit counter. Shifts MSB first
// on each bus clock rising edge; full flags that W bits have arrived.
module pexp_rx_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         shift_en,
    input  logic         bit_in,
    output logic [W-1:0] data,
    output logic         full
);
    localparam int CW = $clog2(W + 2);
    localparam logic [CW-1:0] CMAX = CW'(W + 1);

    logic [CW-1:0] cnt;

    // Count received bits, saturating just past a full byte.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)              cnt <= '0;
        else if (shift_en && cnt != CMAX) cnt <= cnt + 1'b1;
    end

    // Collect bits MSB first.
    always_ff @(posedge clk) begin
        if (!rst_n)        data <= '0;
        else if (shift_en) data <= {data[W-2:0], bit_in};
    end

    assign full = (cnt == CW'(W));
endmodule

// File: rtl/pexp_i2c_engine.sv
// Slave engine of an 8-bit open-drain port expander. Matches the device
// address, loads written bytes into the port register, and answers reads
// with alternating port-level and flag bytes. Assumes clk >= 8x bus rate;
// abort_n is synchronous to clk.
module pexp_i2c_engine
    import pexp_pkg::*;
#(
    parameter int                SYNC_STAGES = 2,
    parameter logic [BYTE_W-1:0] PORT_INIT   = 8'hFF,
    parameter logic [HI_W-1:0]   ADDR_HI     = 3'b110
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              abort_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_oe,
    input  logic [LOW_W-1:0]  addr_low,
    input  logic [BYTE_W-1:0] port_in,
    input  logic [BYTE_W-1:0] flags_in,
    output logic [BYTE_W-1:0] port_out,
    output logic              snap_stb
);
    state_t            state;
    logic              sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic [BYTE_W-1:0] rx_byte;
    logic              rx_full;
    logic              rx_clr;
    logic [BYTE_W-1:0] tx_sr;
    logic [BYTE_W-1:0] flag_hold;
    logic              rd_dir;
    logic              send_flag;
    logic              nack;

    pexp_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    // Restart the bit count on START and at the end of each acknowledge clock.
    assign rx_clr = start_det ||
                    (scl_fall && (state == ST_AACK || state == ST_WACK || state == ST_RACK));

    pexp_rx_shift #(.W(BYTE_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .clr(rx_clr), .shift_en(scl_rise),
        .bit_in(sda_lvl), .data(rx_byte), .full(rx_full)
    );

    // Transaction sequencer: address match, acknowledge, write and read paths.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            sda_oe    <= 1'b0;
            port_out  <= PORT_INIT;
            tx_sr     <= '0;
            flag_hold <= '0;
            snap_stb  <= 1'b0;
            rd_dir    <= 1'b0;
            send_flag <= 1'b0;
            nack      <= 1'b0;
        end else begin
            snap_stb <= 1'b0;
            if (!abort_n) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else if (start_det) begin
                state  <= ST_ADDR;
                sda_oe <= 1'b0;
            end else if (stop_det) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR: begin
                        if (scl_fall && rx_full) begin
                            if (rx_byte[BYTE_W-1:1] == {ADDR_HI, addr_low}) begin
                                rd_dir <= rx_byte[0];
                                sda_oe <= 1'b1;
                                state  <= ST_AACK;
                            end else begin
                                state <= ST_WAIT;
                            end
                        end
                    end
                    ST_AACK: begin
                        if (scl_rise) begin
                            snap_stb  <= 1'b1;
                            tx_sr     <= port_in;
                            flag_hold <= flags_in;
                        end else if (scl_fall) begin
                            send_flag <= 1'b0;
                            if (rd_dir) begin
                                sda_oe <= ~tx_sr[BYTE_W-1];
                                state  <= ST_RDATA;
                            end else begin
                                sda_oe <= 1'b0;
                                state  <= ST_WDATA;
                            end
                        end
                    end
                    ST_WDATA: begin
                        if (scl_fall && rx_full) begin
                            port_out <= rx_byte;
                            sda_oe   <= 1'b1;
                            state    <= ST_WACK;
                        end
                    end
                    ST_WACK: begin
                        if (scl_fall) begin
                            sda_oe <= 1'b0;
                            state  <= ST_WDATA;
                        end
                    end
                    ST_RDATA: begin
                        if (scl_fall) begin
                            if (rx_full) begin
                                sda_oe <= 1'b0;
                                state  <= ST_RACK;
                            end else begin
                                tx_sr  <= {tx_sr[BYTE_W-2:0], 1'b0};
                                sda_oe <= ~tx_sr[BYTE_W-2];
                            end
                        end
                    end
                    ST_RACK: begin
                        if (scl_rise) begin
                            nack <= sda_lvl;
                            if (!sda_lvl) begin
                                if (send_flag) begin
                                    snap_stb  <= 1'b1;
                                    tx_sr     <= port_in;
                                    flag_hold <= flags_in;
                                end else begin
                                    tx_sr <= flag_hold;
                                end
                            end
                        end else if (scl_fall) begin
                            if (nack) begin
                                state <= ST_WAIT;
                            end else begin
                                send_flag <= ~send_flag;
                                sda_oe    <= ~tx_sr[BYTE_W-1];
                                state     <= ST_RDATA;
                            end
                        end
                    end
                    ST_IDLE, ST_WAIT: ;
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/pexp_i2c_checker.sv
// Temporal checks on the port expander engine, bound to every instance.
module pexp_i2c_checker
    import pexp_pkg::*;
#(
    parameter logic [BYTE_W-1:0] PORT_INIT = 8'hFF
) (
    input logic              clk,
    input logic              rst_n,
    input logic              abort_n,
    input logic              sda_oe,
    input logic              snap_stb,
    input logic [BYTE_W-1:0] port_out,
    input state_t            st
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!sda_oe && !snap_stb && port_out == PORT_INIT));

    assert_drive_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sda_oe |-> (st == ST_AACK || st == ST_WACK || st == ST_RDATA));

    assert_port_write_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(port_out) |-> $past(st) == ST_WDATA);

    assert_snap_in_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
        snap_stb |-> ($past(st) == ST_AACK || $past(st) == ST_RACK));

    assert_strobe_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        snap_stb |=> !snap_stb);

    assert_abort_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !abort_n |=> (!sda_oe && st == ST_IDLE));
endmodule

bind pexp_i2c_engine pexp_i2c_checker #(.PORT_INIT(PORT_INIT)) u_chk (
    .clk(clk), .rst_n(rst_n), .abort_n(abort_n), .sda_oe(sda_oe),
    .snap_stb(snap_stb), .port_out(port_out), .st(state)
);

// File: tb/tb_pexp_i2c_engine.sv
// Self-checking bench: a vector table of single transfers, then directed
// sequences for reset, multi-byte, NACK, abort, STOP and repeated START.
module tb_pexp_i2c_engine;
    localparam int Q = 5;                 // quarter bus period in clocks
    localparam logic [3:0] LOW = 4'b0101; // device address 7'h65

    typedef struct packed {
        logic       rd;
        logic [6:0] addr;
        logic [7:0] val;
        logic [7:0] flg;
        logic       ack;
    } vec_t;

    localparam vec_t VEC [8] = '{
        '{1'b0, 7'h65, 8'h3C, 8'h00, 1'b1},
        '{1'b0, 7'h64, 8'hAA, 8'h00, 1'b0},
        '{1'b1, 7'h65, 8'h5A, 8'h81, 1'b1},
        '{1'b0, 7'h65, 8'h00, 8'h00, 1'b1},
        '{1'b1, 7'h75, 8'hC3, 8'h18, 1'b0},
        '{1'b0, 7'h25, 8'h66, 8'h00, 1'b0},
        '{1'b1, 7'h65, 8'hF0, 8'h0F, 1'b1},
        '{1'b0, 7'h65, 8'hFF, 8'h00, 1'b1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic abort_n = 1'b1;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic [7:0] port_in = 8'h00;
    logic [7:0] flags_in = 8'h00;
    logic sda_oe, snap_stb;
    logic [7:0] port_out;
    logic sda_line;
    int n_chk = 0;
    int n_err = 0;
    int snap_cnt = 0;
    logic oe_seen = 1'b0;
    logic oe_watch = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    assign sda_line = m_sda & ~sda_oe;

    pexp_i2c_engine dut (
        .clk(clk), .rst_n(rst_n), .abort_n(abort_n), .scl_in(m_scl),
        .sda_in(sda_line), .sda_oe(sda_oe), .addr_low(LOW), .port_in(port_in),
        .flags_in(flags_in), .port_out(port_out), .snap_stb(snap_stb)
    );

    always @(posedge clk) begin
        if (snap_stb) snap_cnt <= snap_cnt + 1;
        if (oe_watch && sda_oe) oe_seen <= 1'b1;
    end

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic i2c_start();
        m_sda = 1'b1; wq();
        m_scl = 1'b1; wq();
        m_sda = 1'b0; wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic i2c_stop();
        m_sda = 1'b0; wq();
        m_scl = 1'b1; wq();
        m_sda = 1'b1; wq();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; wq();
            m_scl = 1'b1; wq(); wq();
            m_scl = 1'b0; wq();
        end
        m_sda = 1'b1; wq();
        m_scl = 1'b1; wq();
        ack = ~sda_line; wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            m_sda = 1'b1; wq();
            m_scl = 1'b1; wq();
            b[i] = sda_line; wq();
            m_scl = 1'b0; wq();
        end
        m_sda = ~give_ack; wq();
        m_scl = 1'b1; wq(); wq();
        m_scl = 1'b0; wq();
        m_sda = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        logic a, a2;
        logic [7:0] b0, b1, b2, b3, prev;
        int s0;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 oe", sda_oe, 0);
        chk("R1 port", port_out, 8'hFF);
        chk("R1 strobe", snap_stb, 0);

        // Vector table walk (R2, R3, R4, R6)
        for (int i = 0; i < 8; i++) begin
            prev = port_out;
            s0 = snap_cnt;
            port_in = VEC[i].rd ? VEC[i].val : ~VEC[i].val;
            flags_in = VEC[i].flg;
            i2c_start();
            send_byte({VEC[i].addr, VEC[i].rd}, a);
            chk("R2 ack", a, VEC[i].ack);
            if (a && !VEC[i].rd) begin
                send_byte(VEC[i].val, a2);
                chk("R3 data ack", a2, 1);
                chk("R3 port", port_out, VEC[i].val);
            end
            if (a && VEC[i].rd) begin
                recv_byte(1'b1, b0);
                recv_byte(1'b0, b1);
                chk("R4 port byte", b0, VEC[i].val);
                chk("R4 flag byte", b1, VEC[i].flg);
            end
            i2c_stop();
            chk("R6 strobes", snap_cnt - s0, VEC[i].ack ? 1 : 0);
            if (!VEC[i].ack || VEC[i].rd) chk("R2 port kept", port_out, prev);
        end

        // R3: multi-byte write updates on every byte
        i2c_start();
        send_byte({7'h65, 1'b0}, a);
        send_byte(8'h11, a);
        chk("R3 byte1", port_out, 8'h11);
        send_byte(8'h22, a);
        chk("R3 byte2 ack", a, 1);
        chk("R3 byte2", port_out, 8'h22);
        i2c_stop();

        // R5: four-byte read with inputs changing mid-transfer
        s0 = snap_cnt;
        port_in = 8'hA5; flags_in = 8'h21;
        i2c_start();
        send_byte({7'h65, 1'b1}, a);
        recv_byte(1'b1, b0);
        port_in = 8'h3E; flags_in = 8'h44;
        recv_byte(1'b1, b1);
        recv_byte(1'b1, b2);
        recv_byte(1'b0, b3);
        i2c_stop();
        chk("R5 byte0", b0, 8'hA5);
        chk("R5 byte1", b1, 8'h21);
        chk("R5 byte2", b2, 8'h3E);
        chk("R5 byte3", b3, 8'h44);
        chk("R6 resample strobes", snap_cnt - s0, 2);

        // R7: master NACK releases the line
        port_in = 8'h00;
        i2c_start();
        send_byte({7'h65, 1'b1}, a);
        recv_byte(1'b0, b0);
        chk("R7 first byte", b0, 8'h00);
        oe_watch = 1'b1;
        recv_byte(1'b1, b1);
        oe_watch = 1'b0;
        chk("R7 line released", b1, 8'hFF);
        chk("R7 no drive", oe_seen, 0);
        i2c_stop();
        chk("R7 port kept", port_out, 8'h22);

        // R8: abort mid-write
        i2c_start();
        send_byte({7'h65, 1'b0}, a);
        abort_n = 1'b0;
        repeat (4) @(negedge clk);
        abort_n = 1'b1;
        chk("R8 released", sda_oe, 0);
        send_byte(8'h5A, a);
        chk("R8 no ack", a, 0);
        chk("R8 port kept", port_out, 8'h22);
        i2c_stop();
        i2c_start();
        send_byte({7'h65, 1'b0}, a);
        send_byte(8'h77, a);
        i2c_stop();
        chk("R8 recovers", port_out, 8'h77);

        // R10: bytes after STOP are ignored
        i2c_start();
        send_byte({7'h65, 1'b0}, a);
        send_byte(8'h03, a);
        i2c_stop();
        send_byte(8'hEE, a);
        chk("R10 no ack", a, 0);
        chk("R10 port kept", port_out, 8'h03);
        i2c_stop();

        // R9: write then repeated START read
        port_in = 8'hC6;
        i2c_start();
        send_byte({7'h65, 1'b0}, a);
        send_byte(8'h99, a);
        i2c_start();
        send_byte({7'h65, 1'b1}, a);
        chk("R9 read ack", a, 1);
        recv_byte(1'b0, b0);
        i2c_stop();
        chk("R9 port", port_out, 8'h99);
        chk("R9 read byte", b0, 8'hC6);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule